// File: doc/BRIEF.md
# Core Module System Control Register Bank

A 32-bit memory-mapped register bank for a processor core module. A single synchronous access port selects one word per cycle. Through it the bank serves identification and status constants, two clock-oscillator setting registers that a 16-bit unlock key protects, memory-configuration and initialisation registers, and two flag registers driven through separate set and clear addresses. A control word drives three outputs: a boot-memory remap select, an LED and a one-cycle board-reset request.

A small local interrupt block holds one software-driven interrupt source and two 32-bit masks, one for the normal interrupt and one for the fast interrupt. A single registered interrupt output reports the masked source. A read-only window of 32 byte-wide entries reports the fitted memory module, and its size byte is derived from a parameter. Clock synthesis, voltage control and bus-count timers are not modelled. Voltage-control words read as zero and ignore writes.

Top module: `sysctl_regbank`

## Requirements
- R1: Word 0 reads 0x411A3001 and word 4 reads 0x00100000. Words 1 and 3, the voltage words 32 to 35, words 13 and 15, and every other unlisted word read zero. Writes to unlisted words change nothing.
- R2: A write to the key word (word 5) keeps only bits 15:0. A read returns 0x0001A05F while the kept value is 0xA05F, and the kept value zero-extended otherwise.
- R3: A write to the oscillator word (word 2) or the auxiliary oscillator word (word 7) is stored only while the key word holds 0xA05F. Otherwise it is dropped.
- R4: After reset, word 2 reads 0x01000048, word 7 reads 0x0007FEFF and word 9 reads 0x00000112. Word 8 reads 0x00011122 ORed with a size code for MEM_MB: 0x10 for 256 MB or more, 0x0C for 128 MB or more, 0x08 for 64 MB or more, 0x04 for 32 MB or more, 0 below that. With the default MEM_MB of 128, word 8 reads 0x0001112E.
- R5: Word 12 reads the flag register. Writing word 12 ORs the data into it, and writing word 13 clears every bit set in the data. Words 14 and 15 do the same for the second flag register, which word 14 reads. Both reset to zero.
- R6: A write to the control word (word 3) with bit 3 set drives board_reset_req high for exactly the cycle after the write. board_reset_req is low at all other times.
- R7: On a control write, if data bit 2 differs from bit 2 of the init word, boot_remap becomes the inverse of data bit 2. If data bit 0 differs from init bit 0, led_on becomes data bit 0. Init bits 2 and 0 then take the data bits. After reset boot_remap is 1 and led_on is 0. Writing word 9 directly does not change either output.
- R8: Byte offsets 0x100 to 0x17F read the table entry selected by offset bits 6:2, zero-extended. Entry 0 is 0x80 and entry 2 is 0x04. Entry 31 is the size byte: 64 for 256 MB or more, 32 for 128 MB or more, 16 for 64 MB or more, 4 for 32 MB or more, 2 otherwise. Offsets 0x180 to 0x1FF read zero. Writes anywhere in 0x100 to 0x1FF change nothing.
- R9: The interrupt source is one level bit. Word 20 sets it when data bit 0 is 1 and word 21 clears it when data bit 0 is 1; other data bits are ignored. Word 20 reads the level in bit 0. Words 17 and 25 read the raw level. Word 16 reads level AND the normal mask, and word 24 reads level AND the fast mask. Words 18 and 26 read the masks. Writes to 18 and 26 OR into the masks, and writes to 19 and 27 clear bits.
- R10: core_int is high when the level bit is set and bit 0 of either mask is set. It changes one clock after the write that causes the change.
- R11: A read (acc_en high, acc_wr low) loads rdata at the clock edge, so rdata is valid in the following cycle. rdata holds its value through idle cycles and writes, and resets to zero.
- R12: Word 8 and word 9 store any 32-bit value written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_en | input | 1 | Access valid this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 9 | Byte offset; bits 1:0 ignored |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Registered read data |
| boot_remap | output | 1 | Boot memory remap select |
| led_on | output | 1 | LED drive |
| board_reset_req | output | 1 | One-cycle board reset request |
| core_int | output | 1 | Registered core interrupt |

## Verification
The key-guarded oscillator words get random interleavings of key writes, some correct and some wrong, with oscillator writes and reads. This separates a guard that checks the current key from one that ignores it or latches it once. The flag registers get random mixes of set and clear writes to both registers. A bench model catches a clear that acts as a set, and catches crosstalk between the two registers. Directed sequences drive control words whose bits match or differ from the held init bits, including a direct init write in between, to show that the outputs follow the change test and not the data value. The interrupt words are driven with soft-set data that has bit 0 clear, and with mask changes on each path, to check the one-cycle output latency and the masking.

// File: rtl/sysctl_pkg.sv
// Package: shared word indices, constants, request type and reset-value helpers
// for the system control register bank. Assumes 32-bit words, word-addressed.
package sysctl_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned IDX_W  = 6;
    localparam int unsigned ROM_AW = 5;

    localparam logic [IDX_W-1:0] IDX_IDENT    = 6'd0;
    localparam logic [IDX_W-1:0] IDX_PROC     = 6'd1;
    localparam logic [IDX_W-1:0] IDX_OSC      = 6'd2;
    localparam logic [IDX_W-1:0] IDX_CTRL     = 6'd3;
    localparam logic [IDX_W-1:0] IDX_STAT     = 6'd4;
    localparam logic [IDX_W-1:0] IDX_KEY      = 6'd5;
    localparam logic [IDX_W-1:0] IDX_AUXOSC   = 6'd7;
    localparam logic [IDX_W-1:0] IDX_SDRAM    = 6'd8;
    localparam logic [IDX_W-1:0] IDX_INIT     = 6'd9;
    localparam logic [IDX_W-1:0] IDX_FLG_SET  = 6'd12;
    localparam logic [IDX_W-1:0] IDX_FLG_CLR  = 6'd13;
    localparam logic [IDX_W-1:0] IDX_NVF_SET  = 6'd14;
    localparam logic [IDX_W-1:0] IDX_NVF_CLR  = 6'd15;
    localparam logic [IDX_W-1:0] IDX_IRQ_STAT = 6'd16;
    localparam logic [IDX_W-1:0] IDX_IRQ_RAW  = 6'd17;
    localparam logic [IDX_W-1:0] IDX_IRQ_ENS  = 6'd18;
    localparam logic [IDX_W-1:0] IDX_IRQ_ENC  = 6'd19;
    localparam logic [IDX_W-1:0] IDX_SOFT_SET = 6'd20;
    localparam logic [IDX_W-1:0] IDX_SOFT_CLR = 6'd21;
    localparam logic [IDX_W-1:0] IDX_FIQ_STAT = 6'd24;
    localparam logic [IDX_W-1:0] IDX_FIQ_RAW  = 6'd25;
    localparam logic [IDX_W-1:0] IDX_FIQ_ENS  = 6'd26;
    localparam logic [IDX_W-1:0] IDX_FIQ_ENC  = 6'd27;

    localparam logic [WORD_W-1:0] IDENT_VAL   = 32'h411A_3001;
    localparam logic [WORD_W-1:0] STAT_VAL    = 32'h0010_0000;
    localparam logic [15:0]       UNLOCK_KEY  = 16'hA05F;
    localparam logic [WORD_W-1:0] OSC_RST     = 32'h0100_0048;
    localparam logic [WORD_W-1:0] AUXOSC_RST  = 32'h0007_FEFF;
    localparam logic [WORD_W-1:0] INIT_RST    = 32'h0000_0112;
    localparam logic [WORD_W-1:0] SDRAM_BASE  = 32'h0001_1122;

    // One decoded register-space write per cycle.
    typedef struct packed {
        logic              we;
        logic [IDX_W-1:0]  idx;
        logic [WORD_W-1:0] data;
    } wr_req_t;

    // Size code merged into the SDRAM reset value.
    function automatic logic [WORD_W-1:0] sdram_size_code(input int unsigned mb);
        if (mb >= 256)      return 32'h10;
        else if (mb >= 128) return 32'h0C;
        else if (mb >= 64)  return 32'h08;
        else if (mb >= 32)  return 32'h04;
        else                return 32'h00;
    endfunction

    // Size byte reported in the last presence entry.
    function automatic logic [7:0] presence_size(input int unsigned mb);
        if (mb >= 256)      return 8'd64;
        else if (mb >= 128) return 8'd32;
        else if (mb >= 64)  return 8'd16;
        else if (mb >= 32)  return 8'd4;
        else                return 8'd2;
    endfunction

endpackage

// File: rtl/sysctl_presence_rom.sv
// Module: read-only memory-presence table of 2**ROM_AW byte entries.
// Combinational lookup; the last entry carries the size byte for MEM_MB.
module sysctl_presence_rom
    import sysctl_pkg::*;
#(
    parameter int unsigned MEM_MB = 128,
    parameter int unsigned AW     = ROM_AW
) (
    input  logic [AW-1:0] entry,
    output logic [7:0]    value
);
    localparam int unsigned LAST = (1 << AW) - 1;
    localparam logic [7:0]  SIZE_BYTE = presence_size(MEM_MB);

    // Table lookup, size entry computed from the parameter.
    always_comb begin
        if (32'(entry) == LAST) begin
            value = SIZE_BYTE;
        end else begin
            case (32'(entry))
                0:  value = 8'h80;
                1:  value = 8'h08;
                2:  value = 8'h04;
                3:  value = 8'h0B;
                4:  value = 8'h09;
                5:  value = 8'h01;
                6:  value = 8'h40;
                8:  value = 8'h02;
                9:  value = 8'hA0;
                10: value = 8'hA0;
                13: value = 8'h08;
                15: value = 8'h01;
                16: value = 8'h0E;
                17: value = 8'h04;
                18: value = 8'h1C;
                19: value = 8'h01;
                20: value = 8'h02;
                21: value = 8'h20;
                22: value = 8'hC0;
                27: value = 8'h30;
                28: value = 8'h28;
                29: value = 8'h30;
                30: value = 8'h28;
                default: value = 8'h00;
            endcase
        end
    end
endmodule

// File: rtl/sysctl_cfg_regs.sv
// Module: configuration state of the bank: key, oscillators, SDRAM, init,
// two set/clear flag registers and the control-word outputs.
// Assumes at most one write per cycle, already decoded to a word index.
module sysctl_cfg_regs
    import sysctl_pkg::*;
#(
    parameter int unsigned MEM_MB = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  wr_req_t           req,
    output logic [WORD_W-1:0] osc_q,
    output logic [WORD_W-1:0] auxosc_q,
    output logic [15:0]       key_q,
    output logic [WORD_W-1:0] sdram_q,
    output logic [WORD_W-1:0] init_q,
    output logic [WORD_W-1:0] flags_q,
    output logic [WORD_W-1:0] nvflags_q,
    output logic              remap_q,
    output logic              led_q,
    output logic              rst_req_q
);
    localparam logic [WORD_W-1:0] SDRAM_RST = SDRAM_BASE | sdram_size_code(MEM_MB);

    logic unlocked;
    assign unlocked = (key_q == UNLOCK_KEY);

    // Key register and key-guarded oscillator words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_q    <= '0;
            osc_q    <= OSC_RST;
            auxosc_q <= AUXOSC_RST;
        end else if (req.we) begin
            if (req.idx == IDX_KEY)                 key_q    <= req.data[15:0];
            if (req.idx == IDX_OSC && unlocked)     osc_q    <= req.data;
            if (req.idx == IDX_AUXOSC && unlocked)  auxosc_q <= req.data;
        end
    end

    // Plain SDRAM configuration word.
    always_ff @(posedge clk) begin
        if (!rst_n)                                 sdram_q <= SDRAM_RST;
        else if (req.we && req.idx == IDX_SDRAM)    sdram_q <= req.data;
    end

    // Init word: full write at its own index, bits 2 and 0 from control writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            init_q <= INIT_RST;
        end else if (req.we && req.idx == IDX_INIT) begin
            init_q <= req.data;
        end else if (req.we && req.idx == IDX_CTRL) begin
            init_q[2] <= req.data[2];
            init_q[0] <= req.data[0];
        end
    end

    // Control outputs: act on a change against the held init bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remap_q   <= 1'b1;
            led_q     <= 1'b0;
            rst_req_q <= 1'b0;
        end else begin
            rst_req_q <= req.we && (req.idx == IDX_CTRL) && req.data[3];
            if (req.we && req.idx == IDX_CTRL) begin
                if (req.data[2] != init_q[2]) remap_q <= ~req.data[2];
                if (req.data[0] != init_q[0]) led_q   <= req.data[0];
            end
        end
    end

    // Set/clear flag pairs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q   <= '0;
            nvflags_q <= '0;
        end else if (req.we) begin
            case (req.idx)
                IDX_FLG_SET: flags_q   <= flags_q | req.data;
                IDX_FLG_CLR: flags_q   <= flags_q & ~req.data;
                IDX_NVF_SET: nvflags_q <= nvflags_q | req.data;
                IDX_NVF_CLR: nvflags_q <= nvflags_q & ~req.data;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/sysctl_intc.sv
// Module: local interrupt block with one soft level bit and separate
// normal/fast masks. The combined output is registered (one-cycle latency).
module sysctl_intc
    import sysctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  wr_req_t           req,
    output logic              level_q,
    output logic [WORD_W-1:0] irq_en_q,
    output logic [WORD_W-1:0] fiq_en_q,
    output logic              int_q
);
    // Soft level bit: only data bit 0 acts.
    always_ff @(posedge clk) begin
        if (!rst_n)                                                  level_q <= 1'b0;
        else if (req.we && req.idx == IDX_SOFT_SET && req.data[0])   level_q <= 1'b1;
        else if (req.we && req.idx == IDX_SOFT_CLR && req.data[0])   level_q <= 1'b0;
    end

    // Mask registers with set/clear addresses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_en_q <= '0;
            fiq_en_q <= '0;
        end else if (req.we) begin
            case (req.idx)
                IDX_IRQ_ENS: irq_en_q <= irq_en_q | req.data;
                IDX_IRQ_ENC: irq_en_q <= irq_en_q & ~req.data;
                IDX_FIQ_ENS: fiq_en_q <= fiq_en_q | req.data;
                IDX_FIQ_ENC: fiq_en_q <= fiq_en_q & ~req.data;
                default: ;
            endcase
        end
    end

    // Registered combined interrupt from the settled state.
    always_ff @(posedge clk) begin
        if (!rst_n) int_q <= 1'b0;
        else        int_q <= level_q & (irq_en_q[0] | fiq_en_q[0]);
    end
endmodule

// File: rtl/sysctl_regbank.sv
// Module: top of the system control register bank. Decodes the word port,
// routes writes to the config and interrupt blocks and registers read data.
// Assumes one access per cycle; offsets 0x100..0x1FF form the read-only window.
module sysctl_regbank
    import sysctl_pkg::*;
#(
    parameter int unsigned MEM_MB = 128,
    parameter int unsigned ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_en,
    input  logic              acc_wr,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [31:0]       acc_wdata,
    output logic [31:0]       acc_rdata,
    output logic              boot_remap,
    output logic              led_on,
    output logic              board_reset_req,
    output logic              core_int
);
    localparam int unsigned WIN_BIT = ADDR_W - 1;
    localparam int unsigned HI_BIT  = ADDR_W - 2;

    wr_req_t           req;
    logic [IDX_W-1:0]  idx;
    logic [WORD_W-1:0] osc_q, auxosc_q, sdram_q, init_q, flags_q, nvflags_q;
    logic [15:0]       lock_q;
    logic              soft_lvl;
    logic [WORD_W-1:0] irq_en_q, fiq_en_q;
    logic [7:0]        rom_byte;
    logic [WORD_W-1:0] rd_next;
    logic [WORD_W-1:0] lvl_word;

    assign idx      = acc_addr[IDX_W+1:2];
    assign lvl_word = {{(WORD_W-1){1'b0}}, soft_lvl};

    // Write request: register space only, window writes dropped.
    always_comb begin
        req.we   = acc_en && acc_wr && !acc_addr[WIN_BIT];
        req.idx  = idx;
        req.data = acc_wdata;
    end

    sysctl_cfg_regs #(.MEM_MB(MEM_MB)) cfg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .osc_q     (osc_q),
        .auxosc_q  (auxosc_q),
        .key_q     (lock_q),
        .sdram_q   (sdram_q),
        .init_q    (init_q),
        .flags_q   (flags_q),
        .nvflags_q (nvflags_q),
        .remap_q   (boot_remap),
        .led_q     (led_on),
        .rst_req_q (board_reset_req)
    );

    sysctl_intc intc_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .level_q  (soft_lvl),
        .irq_en_q (irq_en_q),
        .fiq_en_q (fiq_en_q),
        .int_q    (core_int)
    );

    sysctl_presence_rom #(.MEM_MB(MEM_MB), .AW(ROM_AW)) rom_i (
        .entry (acc_addr[ROM_AW+1:2]),
        .value (rom_byte)
    );

    // Read multiplexer for the addressed word.
    always_comb begin
        rd_next = '0;
        if (acc_addr[WIN_BIT]) begin
            if (!acc_addr[HI_BIT]) rd_next = {24'b0, rom_byte};
        end else begin
            case (idx)
                IDX_IDENT:    rd_next = IDENT_VAL;
                IDX_STAT:     rd_next = STAT_VAL;
                IDX_OSC:      rd_next = osc_q;
                IDX_KEY:      rd_next = (lock_q == UNLOCK_KEY) ? {15'b0, 1'b1, lock_q}
                                                               : {16'b0, lock_q};
                IDX_AUXOSC:   rd_next = auxosc_q;
                IDX_SDRAM:    rd_next = sdram_q;
                IDX_INIT:     rd_next = init_q;
                IDX_FLG_SET:  rd_next = flags_q;
                IDX_NVF_SET:  rd_next = nvflags_q;
                IDX_IRQ_STAT: rd_next = lvl_word & irq_en_q;
                IDX_IRQ_RAW:  rd_next = lvl_word;
                IDX_IRQ_ENS:  rd_next = irq_en_q;
                IDX_SOFT_SET: rd_next = lvl_word;
                IDX_FIQ_STAT: rd_next = lvl_word & fiq_en_q;
                IDX_FIQ_RAW:  rd_next = lvl_word;
                IDX_FIQ_ENS:  rd_next = fiq_en_q;
                default:      rd_next = '0;
            endcase
        end
    end

    // Registered read data, held between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)                 acc_rdata <= '0;
        else if (acc_en && !acc_wr) acc_rdata <= rd_next;
    end
endmodule

// File: rtl/sysctl_regbank_chk.sv
// Checker: temporal properties of the register bank, bound to the top.
module sysctl_regbank_chk
    import sysctl_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        acc_en,
    input logic        acc_wr,
    input logic [8:0]  acc_addr,
    input logic [31:0] acc_wdata,
    input logic        board_reset_req,
    input logic [31:0] osc_q,
    input logic [15:0] lock_q,
    input logic [31:0] flags_q,
    input logic        soft_lvl
);
    logic wr_reg;
    assign wr_reg = acc_en && acc_wr && !acc_addr[8];

    p_key_low16_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_reg && acc_addr[7:2] == IDX_KEY) |=> (lock_q == $past(acc_wdata[15:0])));

    p_osc_guard_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_reg && acc_addr[7:2] == IDX_OSC && lock_q != UNLOCK_KEY) |=> $stable(osc_q));

    p_flag_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_reg && acc_addr[7:2] == IDX_FLG_SET) |=> ((flags_q & $past(acc_wdata)) == $past(acc_wdata)));

    p_reset_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_reg && acc_addr[7:2] == IDX_CTRL && acc_wdata[3]) |=> board_reset_req);

    p_reset_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_reg && acc_addr[7:2] == IDX_CTRL && acc_wdata[3]) |=> !board_reset_req);

    p_soft_bit0_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_reg && acc_addr[7:2] == IDX_SOFT_SET && !acc_wdata[0]) |=> $stable(soft_lvl));
endmodule

bind sysctl_regbank sysctl_regbank_chk chk_i (.*);

// File: tb/sysctl_regbank_tb_top.sv
// Bench: directed corner cases plus seeded random key/oscillator and flag traffic.
module sysctl_regbank_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_en = 1'b0, acc_wr = 1'b0;
    logic [8:0]  acc_addr = '0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic        boot_remap, led_on, board_reset_req, core_int;
    int          checks = 0, fails = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    sysctl_regbank dut_i (.*);

    function automatic logic [8:0] w(input int i);
        return 9'(i * 4);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        acc_en = 1'b1; acc_wr = 1'b1; acc_addr = a; acc_wdata = d;
        @(negedge clk);
        acc_en = 1'b0; acc_wr = 1'b0;
    endtask

    task automatic rd(input logic [8:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        acc_en = 1'b1; acc_wr = 1'b0; acc_addr = a;
        @(negedge clk);
        acc_en = 1'b0;
        chk(tag, acc_rdata, exp);
    endtask

    function automatic logic [31:0] key_read(input logic [15:0] k);
        return (k == 16'hA05F) ? 32'h0001A05F : {16'b0, k};
    endfunction

    initial begin
        logic [15:0] key_m;
        logic [31:0] osc_m, fl_m, nv_m, d;
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        chk("R11 rdata reset", acc_rdata, 32'h0);
        chk("R7 remap reset", {31'b0, boot_remap}, 1);
        chk("R7 led reset", {31'b0, led_on}, 0);
        chk("R10 int reset", {31'b0, core_int}, 0);
        rst_n = 1'b1;

        // R4 reset values
        rd(w(2), 32'h01000048, "R4 osc");
        rd(w(7), 32'h0007FEFF, "R4 auxosc");
        rd(w(9), 32'h00000112, "R4 init");
        rd(w(8), 32'h0001112E, "R4 sdram");
        // R1 constants and zero words
        rd(w(0), 32'h411A3001, "R1 ident");
        rd(w(4), 32'h00100000, "R1 stat");
        rd(w(1), 0, "R1 word1");
        rd(w(3), 0, "R1 word3");
        rd(w(33), 0, "R1 voltage");
        wr(w(33), 32'hFFFFFFFF);
        rd(w(33), 0, "R1 voltage write ignored");
        wr(w(6), 32'h12345678);
        rd(w(6), 0, "R1 unlisted word");
        // R11 hold through idle and writes
        rd(w(0), 32'h411A3001, "R11 read");
        wr(w(8), 32'hA5A5A5A5);
        repeat (2) @(negedge clk);
        chk("R11 rdata held", acc_rdata, 32'h411A3001);
        // R12 plain words
        rd(w(8), 32'hA5A5A5A5, "R12 sdram rw");
        wr(w(9), 32'h00000112);

        // R2 key
        wr(w(5), 32'hFFFFA05F);
        rd(w(5), 32'h0001A05F, "R2 key match");
        wr(w(5), 32'h0012A05E);
        rd(w(5), 32'h0000A05E, "R2 key low16");
        // R3 guard, directed
        wr(w(2), 32'h11111111);
        rd(w(2), 32'h01000048, "R3 osc locked");
        wr(w(7), 32'h22222222);
        rd(w(7), 32'h0007FEFF, "R3 auxosc locked");
        wr(w(5), 32'hA05F);
        wr(w(7), 32'h33333333);
        rd(w(7), 32'h33333333, "R3 auxosc unlocked");
        // R3 random
        key_m = 16'hA05F; osc_m = 32'h01000048;
        for (int i = 0; i < 80; i++) begin
            int op = $urandom_range(0, 2);
            d = $urandom();
            if (op == 0) begin
                if ($urandom_range(0, 1) == 1) d[15:0] = 16'hA05F;
                wr(w(5), d); key_m = d[15:0];
            end else if (op == 1) begin
                wr(w(2), d);
                if (key_m == 16'hA05F) osc_m = d;
            end else begin
                rd(w(2), osc_m, "R3 osc random");
                rd(w(5), key_read(key_m), "R2 key random");
            end
        end

        // R5 flags random
        fl_m = 0; nv_m = 0;
        for (int i = 0; i < 120; i++) begin
            int op = $urandom_range(12, 16);
            d = $urandom();
            if (op == 16) begin
                rd(w(12), fl_m, "R5 flags");
                rd(w(14), nv_m, "R5 nvflags");
            end else begin
                wr(w(op), d);
                case (op)
                    12: fl_m = fl_m | d;
                    13: fl_m = fl_m & ~d;
                    14: nv_m = nv_m | d;
                    default: nv_m = nv_m & ~d;
                endcase
            end
        end
        rd(w(13), 0, "R1 word13 reads zero");

        // R6 reset pulse
        wr(w(3), 32'h8);
        chk("R6 reset pulse high", {31'b0, board_reset_req}, 1);
        @(negedge clk);
        chk("R6 reset pulse low", {31'b0, board_reset_req}, 0);

        // R7 remap / LED (init bits now 0 after the bit3 write)
        wr(w(3), 32'h5);
        chk("R7 remap after set", {31'b0, boot_remap}, 0);
        chk("R7 led after set", {31'b0, led_on}, 1);
        rd(w(9), 32'h00000117, "R7 init bits updated");
        wr(w(9), 32'h0);
        chk("R7 init write no remap", {31'b0, boot_remap}, 0);
        chk("R7 init write no led", {31'b0, led_on}, 1);
        wr(w(3), 32'h0);
        chk("R7 equal bits hold remap", {31'b0, boot_remap}, 0);
        chk("R7 equal bits hold led", {31'b0, led_on}, 1);
        wr(w(3), 32'h4);
        wr(w(3), 32'h0);
        chk("R7 remap restored", {31'b0, boot_remap}, 1);

        // R8 window
        rd(9'h100, 32'h80, "R8 entry0");
        rd(9'h108, 32'h04, "R8 entry2");
        rd(9'h17C, 32'h20, "R8 size entry");
        rd(9'h180, 0, "R8 upper zero");
        rd(9'h1FC, 0, "R8 top zero");
        wr(9'h108, 32'hFFFFFFFF);
        rd(9'h108, 32'h04, "R8 window write ignored");

        // R9 / R10 interrupt block
        wr(w(26), 32'h1);
        rd(w(25), 0, "R9 raw zero");
        wr(w(20), 32'h2);
        rd(w(20), 0, "R9 soft set bit0 only");
        wr(w(20), 32'h1);
        chk("R10 int not yet", {31'b0, core_int}, 0);
        @(negedge clk);
        chk("R10 int raised", {31'b0, core_int}, 1);
        rd(w(24), 1, "R9 fiq status");
        rd(w(16), 0, "R9 irq status masked");
        rd(w(17), 1, "R9 irq raw");
        wr(w(18), 32'hFFFF0001);
        rd(w(18), 32'hFFFF0001, "R9 irq enable set");
        wr(w(19), 32'hFFFF0000);
        rd(w(18), 32'h1, "R9 irq enable clear");
        wr(w(27), 32'h1);
        rd(w(26), 0, "R9 fiq enable clear");
        chk("R10 int via irq mask", {31'b0, core_int}, 1);
        wr(w(21), 32'hE);
        rd(w(17), 1, "R9 soft clear bit0 only");
        wr(w(21), 32'h1);
        chk("R10 int still high", {31'b0, core_int}, 1);
        @(negedge clk);
        chk("R10 int dropped", {31'b0, core_int}, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule